// File: doc/BRIEF.md
# Per-Packet Crypto Context Capture

This block watches a segmented ingress stream that carries eight segments per beat. The segments are grouped into four pairs: pair p owns segments 2p and 2p+1. Each pair has its own decryption control sideband. When a start-of-packet strobe appears in either segment of a pair on a valid beat, the block latches that pair's sideband. It then cleans up the captured fields according to the pair's crypto mode and holds the resulting context steady for later pipeline stages. The context stays in place until the next start of packet on the same pair.

Normalization depends on the mode:
- Offsets and cipher-suite codes are forced into the legal set for the mode.
- The SA index is split into an internal/external flag and a secure-channel number.
- The 128-bit tag input is read either as packed metadata fields or as a raw integrity check value.

Misconfigured packets set a per-pair error flag that stays set until reset, so software can find a bad setup long after the packet has gone. Downstream stages read the context as soon as the one-cycle update pulse appears.

Top module: `crypto_ctx_capture`

## Requirements
- R1: Pair p captures its sideband on a clock edge where `beat_valid` is 1 and `seg_sop[2p]` or `seg_sop[2p+1]` is 1. The new context appears at the outputs one cycle later, together with a one-cycle `ctx_update[p]` pulse. Other pairs are not affected.
- R2: Without such a capture, a pair's context outputs and its `ctx_update` stay unchanged at 0. This includes a start-of-packet strobe on a beat where `beat_valid` is 0.
- R3: Mode codes are 00 MACsec, 01 IPsec, 10 bulk GCM, 11 bulk ECB. The mode is taken from `mode_in` at capture and returned on `ctx_mode`. In MACsec mode only offsets 0, 30 and 50 are kept. Any other offset becomes 0 and counts as a configuration error.
- R4: In the two bulk modes any offset from 0 to 63 passes unchanged. In IPsec mode the offset is ignored: the output is 0 and no error is raised.
- R5: In the bulk modes, suite codes 2 and 3 are unsupported. They are captured with bit 1 cleared and count as a configuration error. In MACsec and IPsec the suite passes unchanged. `ctx_xpn` is bit 1 of the captured suite.
- R6: `ctx_external` is 1 when the SA index is 1024 or more. `ctx_sc_num` is the SA index shifted right by log2(SAS_PER_SC); the default is 4 SAs per channel, a shift by 2.
- R7: In MACsec and IPsec the tag input is split into SSCI (bits 31:0), upper packet-number bits (63:32) and replay window (95:64), and `ctx_icv` is 0. In bulk GCM the whole input appears on `ctx_icv` and the split fields are 0. In bulk ECB all four are 0.
- R8: In bulk ECB, auth-only is captured as 0, and an auth-only request counts as a configuration error. In both bulk modes, replay enable is captured as 0.
- R9: When bypass is set, auth-only and replay enable are captured as 0 and no configuration error is raised.
- R10: `cfg_err[p]` goes high one cycle after a capture that has a configuration error. It stays high through later clean captures until reset.
- R11: During and after synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | Stream beat valid |
| seg_sop | input | 8 | Start of packet per segment |
| mode_in | input | 8 | Crypto mode, 2 bits per pair |
| bypass_in | input | 4 | Bypass request per pair |
| auth_only_in | input | 4 | Authenticate-only request per pair |
| suite_in | input | 8 | Cipher-suite code, 2 bits per pair |
| offset_in | input | 24 | Confidentiality offset, 6 bits per pair |
| replay_en_in | input | 4 | Replay protection enable per pair |
| sa_index_in | input | 80 | SA index, 20 bits per pair |
| tag_in | input | 512 | Tag/metadata word, 128 bits per pair |
| ctx_update | output | 4 | One-cycle pulse after capture |
| ctx_mode | output | 8 | Captured mode |
| ctx_bypass | output | 4 | Captured bypass |
| ctx_auth_only | output | 4 | Sanitized auth-only |
| ctx_suite | output | 8 | Sanitized suite code |
| ctx_xpn | output | 4 | 64-bit packet numbering in use |
| ctx_offset | output | 24 | Effective offset |
| ctx_replay_en | output | 4 | Sanitized replay enable |
| ctx_external | output | 4 | SA index is external |
| ctx_sc_num | output | 72 | Secure-channel number, 18 bits per pair |
| ctx_ssci | output | 128 | SSCI field |
| ctx_pn_hi | output | 128 | Upper packet-number field |
| ctx_replay_win | output | 128 | Replay window field |
| ctx_icv | output | 512 | Integrity check value |
| cfg_err | output | 4 | Sticky configuration error |

## Verification
A context register that fails to hold, or that loads on the wrong pair, shows up as changed context fields or a stray `ctx_update` on the cycle after the edge that caused it. A missed capture shows the old values at that same sample point. Errors in mode-dependent cleanup are caught one cycle after capture by comparing the fields against constants worked out from the requirements. A wrong error flag shows immediately, and a flag that fails to stay set shows on the next clean capture. The sequence runs captures on every pair and in every mode, and it includes the SA boundary at 1023 and 1024.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int SA_W         = 20;
    localparam int OFS_W        = 6;
    localparam int TAG_W        = 128;
    localparam int META_W       = 32;
    localparam int INT_SA_LIMIT = 1024;

    typedef enum logic [1:0] {
        MODE_MACSEC = 2'b00,
        MODE_IPSEC  = 2'b01,
        MODE_BULK   = 2'b10,
        MODE_ECB    = 2'b11
    } crypto_mode_e;

    // Raw sideband of one pair
    typedef struct packed {
        logic             bypass;
        logic             auth_only;
        logic [1:0]       suite;
        logic [OFS_W-1:0] offset;
        logic             replay_en;
        logic [SA_W-1:0]  sa_index;
        logic [TAG_W-1:0] tag;
    } side_t;

    // Decoded context of one pair
    typedef struct packed {
        crypto_mode_e      mode;
        logic              bypass;
        logic              auth_only;
        logic [1:0]        suite;
        logic              xpn;
        logic [OFS_W-1:0]  offset;
        logic              replay_en;
        logic              external;
        logic [SA_W-1:0]   sa_index;
        logic [META_W-1:0] ssci;
        logic [META_W-1:0] pn_hi;
        logic [META_W-1:0] replay_win;
        logic [TAG_W-1:0]  icv;
    } ctx_t;

    function automatic logic is_bulk(crypto_mode_e m);
        return (m == MODE_BULK) || (m == MODE_ECB);
    endfunction

    function automatic logic macsec_ofs_ok(logic [OFS_W-1:0] o);
        return (o == OFS_W'(0)) || (o == OFS_W'(30)) || (o == OFS_W'(50));
    endfunction

endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
    import ctx_pkg::*;
(
    input  side_t        sd,
    input  crypto_mode_e mode,
    output ctx_t         dec,
    output logic         err
);
    logic ofs_bad, suite_bad, auth_bad;

    always_comb begin
        dec          = '0;
        dec.mode     = mode;
        dec.bypass   = sd.bypass;
        dec.sa_index = sd.sa_index;
        dec.external = (sd.sa_index >= SA_W'(INT_SA_LIMIT));
        dec.auth_only = sd.auth_only & ~sd.bypass & (mode != MODE_ECB);
        dec.replay_en = sd.replay_en & ~sd.bypass & ~is_bulk(mode);
        dec.suite     = is_bulk(mode) ? {1'b0, sd.suite[0]} : sd.suite;
        dec.xpn       = dec.suite[1];
        ofs_bad       = 1'b0;
        case (mode)
            MODE_MACSEC: begin
                ofs_bad    = !macsec_ofs_ok(sd.offset);
                dec.offset = ofs_bad ? '0 : sd.offset;
            end
            MODE_IPSEC:  dec.offset = '0;
            default:     dec.offset = sd.offset;
        endcase
        case (mode)
            MODE_MACSEC, MODE_IPSEC: begin
                dec.ssci       = sd.tag[META_W-1:0];
                dec.pn_hi      = sd.tag[2*META_W-1:META_W];
                dec.replay_win = sd.tag[3*META_W-1:2*META_W];
            end
            MODE_BULK: dec.icv = sd.tag;
            default:   ;
        endcase
        suite_bad = is_bulk(mode) & sd.suite[1];
        auth_bad  = (mode == MODE_ECB) & sd.auth_only;
        err       = ~sd.bypass & (ofs_bad | suite_bad | auth_bad);
    end
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  ctx_t next_ctx,
    input  logic next_err,
    output ctx_t ctx_q,
    output logic err_q,
    output logic update_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q    <= '0;
            err_q    <= 1'b0;
            update_q <= 1'b0;
        end else begin
            update_q <= capture;
            if (capture) ctx_q <= next_ctx;
            err_q <= err_q | (capture & next_err);
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(ctx_q) && !update_q); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R10
    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ctx_q.bypass |-> !ctx_q.auth_only && !ctx_q.replay_en); // R9
    AST_MACSEC_OFS: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.mode == MODE_MACSEC) |-> macsec_ofs_ok(ctx_q.offset)); // R3
    AST_BULK_SUITE: assert property (@(posedge clk) disable iff (rst)
        is_bulk(ctx_q.mode) |-> !ctx_q.suite[1] && !ctx_q.replay_en); // R5
    AST_ECB_AUTH: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.mode == MODE_ECB) |-> !ctx_q.auth_only); // R8
    AST_IPSEC_OFS: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.mode == MODE_IPSEC) |-> (ctx_q.offset == '0)); // R4
endmodule

// File: rtl/crypto_ctx_capture.sv
module crypto_ctx_capture
    import ctx_pkg::*;
#(
    parameter int NUM_PAIRS  = 4,
    parameter int SAS_PER_SC = 4,
    localparam int NUM_SEG   = 2 * NUM_PAIRS,
    localparam int SC_SHIFT  = $clog2(SAS_PER_SC),
    localparam int SC_W      = SA_W - SC_SHIFT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        beat_valid,
    input  logic [NUM_SEG-1:0]          seg_sop,
    input  logic [2*NUM_PAIRS-1:0]      mode_in,
    input  logic [NUM_PAIRS-1:0]        bypass_in,
    input  logic [NUM_PAIRS-1:0]        auth_only_in,
    input  logic [2*NUM_PAIRS-1:0]      suite_in,
    input  logic [OFS_W*NUM_PAIRS-1:0]  offset_in,
    input  logic [NUM_PAIRS-1:0]        replay_en_in,
    input  logic [SA_W*NUM_PAIRS-1:0]   sa_index_in,
    input  logic [TAG_W*NUM_PAIRS-1:0]  tag_in,
    output logic [NUM_PAIRS-1:0]        ctx_update,
    output logic [2*NUM_PAIRS-1:0]      ctx_mode,
    output logic [NUM_PAIRS-1:0]        ctx_bypass,
    output logic [NUM_PAIRS-1:0]        ctx_auth_only,
    output logic [2*NUM_PAIRS-1:0]      ctx_suite,
    output logic [NUM_PAIRS-1:0]        ctx_xpn,
    output logic [OFS_W*NUM_PAIRS-1:0]  ctx_offset,
    output logic [NUM_PAIRS-1:0]        ctx_replay_en,
    output logic [NUM_PAIRS-1:0]        ctx_external,
    output logic [SC_W*NUM_PAIRS-1:0]   ctx_sc_num,
    output logic [META_W*NUM_PAIRS-1:0] ctx_ssci,
    output logic [META_W*NUM_PAIRS-1:0] ctx_pn_hi,
    output logic [META_W*NUM_PAIRS-1:0] ctx_replay_win,
    output logic [TAG_W*NUM_PAIRS-1:0]  ctx_icv,
    output logic [NUM_PAIRS-1:0]        cfg_err
);
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        side_t        sd;
        crypto_mode_e mode;
        ctx_t         dec, held;
        logic         dec_err, capture;

        assign mode = crypto_mode_e'(mode_in[2*p +: 2]);
        assign sd   = '{bypass:    bypass_in[p],
                        auth_only: auth_only_in[p],
                        suite:     suite_in[2*p +: 2],
                        offset:    offset_in[OFS_W*p +: OFS_W],
                        replay_en: replay_en_in[p],
                        sa_index:  sa_index_in[SA_W*p +: SA_W],
                        tag:       tag_in[TAG_W*p +: TAG_W]};
        assign capture = beat_valid & (seg_sop[2*p] | seg_sop[2*p+1]);

        ctx_decode u_dec (.sd(sd), .mode(mode), .dec(dec), .err(dec_err));

        ctx_slot u_slot (
            .clk(clk), .rst(rst), .capture(capture),
            .next_ctx(dec), .next_err(dec_err),
            .ctx_q(held), .err_q(cfg_err[p]), .update_q(ctx_update[p])
        );

        assign ctx_mode[2*p +: 2]                = held.mode;
        assign ctx_bypass[p]                     = held.bypass;
        assign ctx_auth_only[p]                  = held.auth_only;
        assign ctx_suite[2*p +: 2]               = held.suite;
        assign ctx_xpn[p]                        = held.xpn;
        assign ctx_offset[OFS_W*p +: OFS_W]      = held.offset;
        assign ctx_replay_en[p]                  = held.replay_en;
        assign ctx_external[p]                   = held.external;
        assign ctx_sc_num[SC_W*p +: SC_W]        = SC_W'(held.sa_index >> SC_SHIFT);
        assign ctx_ssci[META_W*p +: META_W]      = held.ssci;
        assign ctx_pn_hi[META_W*p +: META_W]     = held.pn_hi;
        assign ctx_replay_win[META_W*p +: META_W] = held.replay_win;
        assign ctx_icv[TAG_W*p +: TAG_W]         = held.icv;
    end
endmodule

// File: tb/crypto_ctx_capture_test.sv
module crypto_ctx_capture_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int SCW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic beat_valid = 1'b0;
    logic [7:0]   seg_sop = '0;
    logic [7:0]   mode_in = '0;
    logic [3:0]   bypass_in = '0, auth_only_in = '0, replay_en_in = '0;
    logic [7:0]   suite_in = '0;
    logic [23:0]  offset_in = '0;
    logic [79:0]  sa_index_in = '0;
    logic [511:0] tag_in = '0;
    logic [3:0]   ctx_update, ctx_bypass, ctx_auth_only, ctx_xpn, ctx_replay_en, ctx_external, cfg_err;
    logic [7:0]   ctx_mode, ctx_suite;
    logic [23:0]  ctx_offset;
    logic [71:0]  ctx_sc_num;
    logic [127:0] ctx_ssci, ctx_pn_hi, ctx_replay_win;
    logic [511:0] ctx_icv;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    crypto_ctx_capture uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pair(int p, logic [1:0] md, logic byp, logic ao, logic [1:0] su,
                            logic [5:0] ofs, logic rep, logic [19:0] sa, logic [127:0] tg);
        mode_in[2*p +: 2]     = md;
        bypass_in[p]          = byp;
        auth_only_in[p]       = ao;
        suite_in[2*p +: 2]    = su;
        offset_in[6*p +: 6]   = ofs;
        replay_en_in[p]       = rep;
        sa_index_in[20*p +: 20] = sa;
        tag_in[128*p +: 128]  = tg;
    endtask

    // drive one beat at negedge, sample at the following negedge
    task automatic beat(logic [7:0] sop, logic vld);
        @(negedge clk);
        seg_sop = sop; beat_valid = vld;
        @(negedge clk);
        seg_sop = '0; beat_valid = 1'b0;
    endtask

    localparam logic [127:0] TAG_A = 128'h0123_4567_89AB_CDEF_1111_2222_3333_4444;

    task automatic t_reset();
        chk("R11 update", ctx_update, 0);
        chk("R11 mode", ctx_mode, 0);
        chk("R11 offset", ctx_offset, 0);
        chk("R11 icv", ctx_icv[127:0], 0);
        chk("R11 err", cfg_err, 0);
    endtask

    task automatic t_macsec();
        set_pair(0, 2'b00, 0, 0, 2'd3, 6'd30, 1, 20'd5, TAG_A);
        beat(8'b0000_0010, 1);
        chk("R1 update pulse p0 only", ctx_update, 4'b0001);
        chk("R3 mode", ctx_mode[1:0], 2'b00);
        chk("R3 offset 30 kept", ctx_offset[5:0], 30);
        chk("R5 suite", ctx_suite[1:0], 3);
        chk("R5 xpn", ctx_xpn[0], 1);
        chk("R8 replay kept in macsec", ctx_replay_en[0], 1);
        chk("R6 internal", ctx_external[0], 0);
        chk("R6 sc", ctx_sc_num[SCW-1:0], 1);
        chk("R7 ssci", ctx_ssci[31:0], 32'h3333_4444);
        chk("R7 pn_hi", ctx_pn_hi[31:0], 32'h1111_2222);
        chk("R7 window", ctx_replay_win[31:0], 32'h89AB_CDEF);
        chk("R7 icv zero", ctx_icv[127:0], 0);
        chk("R3 no err", cfg_err[0], 0);
        @(negedge clk);
        chk("R1 pulse one cycle", ctx_update[0], 0);
        set_pair(0, 2'b00, 0, 0, 2'd0, 6'd17, 0, 20'd5, TAG_A);
        beat(8'b0000_0001, 1);
        chk("R3 offset 17 to 0", ctx_offset[5:0], 0);
        chk("R3 err", cfg_err[0], 1);
        set_pair(0, 2'b00, 0, 0, 2'd0, 6'd50, 0, 20'd5, TAG_A);
        beat(8'b0000_0001, 1);
        chk("R3 offset 50 kept", ctx_offset[5:0], 50);
        chk("R10 err sticky", cfg_err[0], 1);
    endtask

    task automatic t_hold();
        set_pair(1, 2'b01, 0, 1, 2'd2, 6'd9, 1, 20'd64, TAG_A);
        beat(8'b0000_0100, 1);
        chk("R1 p1 only", ctx_update, 4'b0010);
        chk("R4 ipsec offset", ctx_offset[11:6], 0);
        chk("R4 ipsec no err", cfg_err[1], 0);
        chk("R5 ipsec suite", ctx_suite[3:2], 2);
        chk("R6 sc p1", ctx_sc_num[2*SCW-1:SCW], 16);
        set_pair(1, 2'b10, 1, 0, 2'd1, 6'd3, 0, 20'd999, '0);
        beat(8'b0000_1000, 0);
        chk("R2 no update", ctx_update, 0);
        chk("R2 mode held", ctx_mode[3:2], 2'b01);
        chk("R2 bypass held", ctx_bypass[1], 0);
        chk("R2 auth held", ctx_auth_only[1], 1);
        chk("R2 window held", ctx_replay_win[63:32], 32'h89AB_CDEF);
    endtask

    task automatic t_bulk();
        set_pair(2, 2'b10, 0, 0, 2'd2, 6'd63, 1, 20'd2000, TAG_A);
        beat(8'b0010_0000, 1);
        chk("R1 p2 only", ctx_update, 4'b0100);
        chk("R4 bulk offset 63", ctx_offset[17:12], 63);
        chk("R5 bulk suite", ctx_suite[5:4], 0);
        chk("R5 bulk xpn", ctx_xpn[2], 0);
        chk("R5 bulk err", cfg_err[2], 1);
        chk("R8 bulk replay off", ctx_replay_en[2], 0);
        chk("R6 external", ctx_external[2], 1);
        chk("R6 sc 500", ctx_sc_num[3*SCW-1:2*SCW], 500);
        chk("R7 icv", ctx_icv[383:256], TAG_A);
        chk("R7 ssci zero", ctx_ssci[95:64], 0);
    endtask

    task automatic t_ipsec_boundary();
        set_pair(3, 2'b01, 0, 0, 2'd0, 6'd40, 0, 20'd1023, '0);
        beat(8'b0100_0000, 1);
        chk("R6 1023 internal", ctx_external[3], 0);
        chk("R4 ipsec offset ignored", ctx_offset[23:18], 0);
        chk("R4 ipsec no err", cfg_err[3], 0);
        set_pair(3, 2'b01, 0, 0, 2'd0, 6'd0, 0, 20'd1024, '0);
        beat(8'b1000_0000, 1);
        chk("R6 1024 external", ctx_external[3], 1);
    endtask

    task automatic t_bypass();
        set_pair(3, 2'b00, 1, 1, 2'd0, 6'd17, 1, 20'd8, '0);
        beat(8'b1000_0000, 1);
        chk("R9 bypass", ctx_bypass[3], 1);
        chk("R9 auth low", ctx_auth_only[3], 0);
        chk("R9 replay low", ctx_replay_en[3], 0);
        chk("R9 no err", cfg_err[3], 0);
    endtask

    task automatic t_ecb();
        set_pair(1, 2'b11, 0, 1, 2'd1, 6'd12, 1, 20'd4, TAG_A);
        beat(8'b0000_0100, 1);
        chk("R8 ecb auth forced", ctx_auth_only[1], 0);
        chk("R8 ecb err", cfg_err[1], 1);
        chk("R8 ecb replay", ctx_replay_en[1], 0);
        chk("R4 ecb offset", ctx_offset[11:6], 12);
        chk("R7 ecb icv zero", ctx_icv[255:128], 0);
        chk("R7 ecb window zero", ctx_replay_win[63:32], 0);
    endtask

    task automatic t_reset_clear();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 reset clears err", cfg_err, 0);
        chk("R11 sc cleared", ctx_sc_num, 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_macsec();
        t_hold();
        t_bulk();
        t_ipsec_boundary();
        t_bypass();
        t_ecb();
        t_reset_clear();
        finish_up();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule